// File: doc/BRIEF.md
# Bit-Slice Unsigned Magnitude Comparator

This block compares two unsigned 4-bit operands and reports whether the first is below, above or equal to the second. It is purely combinational. The outputs follow the operands with no clock and no state.

The comparison is built from identical one-bit stages, linked from bit 0 up to the top bit. Each stage looks at one bit of each operand. It also receives a pair of "below" and "above" flags from the stage under it. If its two bits differ, the stage issues its own verdict. If they match, it forwards the verdict from below unchanged. The bottom stage is fed with both flags clear. The stages carry no equality signal. A single NOR gate on the two flags leaving the top stage produces the equality output.

Top module: `mag_cmp4`

## Requirements
- R1: When `a_i` is greater than `b_i` as unsigned numbers, `gt_o` is 1 and both `lt_o` and `eq_o` are 0.
- R2: When `a_i` is less than `b_i` as unsigned numbers, `lt_o` is 1 and both `gt_o` and `eq_o` are 0.
- R3: When `a_i` equals `b_i`, `eq_o` is 1 and both `lt_o` and `gt_o` are 0. This includes the case where both operands are zero, since the chain starts with both flags clear.
- R4: For every operand pair, exactly one of `lt_o`, `gt_o` and `eq_o` is 1.
- R5: A stage whose operand-A bit is 1 and operand-B bit is 0 reports "above", whatever its lower neighbour reports. So the highest differing bit with A=1 gives `gt_o`=1, even when every lower bit of B exceeds A.
- R6: A stage whose operand-A bit is 0 and operand-B bit is 1 reports "below", whatever its lower neighbour reports. So the highest differing bit with B=1 gives `lt_o`=1, even when every lower bit of A exceeds B.
- R7: A stage whose two bits match forwards its lower neighbour's flags unchanged. So the verdict comes from the highest differing bit, found through any run of matching upper bits.
- R8: Operands are unsigned: bit 3 carries weight 8. For example, 4'b1000 compared with 4'b0111 gives `gt_o`=1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i  | input     | 4     | First operand, unsigned |
| b_i  | input     | 4     | Second operand, unsigned |
| lt_o | output    | 1     | 1 when a_i < b_i |
| gt_o | output    | 1     | 1 when a_i > b_i |
| eq_o | output    | 1     | 1 when a_i == b_i |

## Verification
Assertions are evaluated whenever the logic changes:
- Each stage checks its own above, below and forward rules.
- The top checks that exactly one output is high.
- The top also checks that each output agrees with the arithmetic relation of the operands.

The bench covers two things the per-stage checks cannot show:
- Correct ordering of the chain: the highest differing bit must decide. Directed pairs, in which the lower bits point the opposite way to the top bit, show this.
- Agreement with an unsigned reference compare across all 256 operand pairs.

// File: rtl/mag_cmp_pkg.sv
// Package: shared types for the bit-slice magnitude comparator.
// Assumes: nothing beyond standard SystemVerilog.
package mag_cmp_pkg;

    // Verdict passed from one stage to the next; at most one field set.
    typedef struct packed {
        logic below;
        logic above;
    } cmp_link_t;

    // Link value fed into the least significant stage.
    localparam cmp_link_t LINK_NEUTRAL = '{below: 1'b0, above: 1'b0};

endpackage

// File: rtl/mag_cmp_slice.sv
// Module: one-bit comparator stage.
// Does: produces below/above flags from one bit of each operand and the
//       flags of the stage beneath; matching bits forward those flags.
// Assumes: incoming flags are never both 1 (bottom stage fed with zeros).
module mag_cmp_slice (
    input  logic a_bit,
    input  logic b_bit,
    input  logic below_in,
    input  logic above_in,
    output logic below_out,
    output logic above_out
);

    // Purpose: decide locally on differing bits, otherwise forward.
    always_comb begin
        if (a_bit != b_bit) begin
            above_out = a_bit;
            below_out = b_bit;
        end else begin
            above_out = above_in;
            below_out = below_in;
        end
    end

    // Purpose: guard the stage rules on every evaluation.
    always_comb begin
        // R5
        slice_above_chk: assert (!(a_bit && !b_bit) || (above_out && !below_out));
        // R6
        slice_below_chk: assert (!(!a_bit && b_bit) || (below_out && !above_out));
        // R7
        slice_forward_chk: assert ((a_bit != b_bit) ||
                                   (above_out == above_in && below_out == below_in));
        // R4
        slice_exclusive_chk: assert ((below_in && above_in) || !(below_out && above_out));
    end

endmodule

// File: rtl/mag_cmp_eq_gate.sv
// Module: equality gate at the top of the chain.
// Does: asserts equality when the final link carries neither flag.
// Assumes: the link comes from the most significant stage.
module mag_cmp_eq_gate (
    input  logic below_in,
    input  logic above_in,
    output logic equal_out
);

    // Purpose: single NOR forming the equality flag.
    always_comb begin
        equal_out = ~(below_in | above_in);
    end

endmodule

// File: rtl/mag_cmp4.sv
// Module: unsigned magnitude comparator built from chained one-bit stages.
// Does: links WIDTH stages from bit 0 upward; equality comes from one gate
//       on the top stage's flags.
// Assumes: unsigned operands; WIDTH is 4 in use; purely combinational.
module mag_cmp4 #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic             lt_o,
    output logic             gt_o,
    output logic             eq_o
);
    import mag_cmp_pkg::*;

    localparam int LINKS = WIDTH + 1;

    cmp_link_t link [LINKS];

    // Purpose: feed the bottom stage a neutral verdict.
    always_comb begin
        link[0] = LINK_NEUTRAL;
    end

    // Purpose: one stage per bit, each above the previous.
    for (genvar i = 0; i < WIDTH; i++) begin : g_stage
        mag_cmp_slice u_slice (
            .a_bit     (a_i[i]),
            .b_bit     (b_i[i]),
            .below_in  (link[i].below),
            .above_in  (link[i].above),
            .below_out (link[i+1].below),
            .above_out (link[i+1].above)
        );
    end

    mag_cmp_eq_gate u_eq (
        .below_in  (link[WIDTH].below),
        .above_in  (link[WIDTH].above),
        .equal_out (eq_o)
    );

    // Purpose: expose the top stage's verdict.
    always_comb begin
        lt_o = link[WIDTH].below;
        gt_o = link[WIDTH].above;
    end

    // Purpose: relate outputs to the operands' arithmetic order.
    always_comb begin
        // R1
        top_gt_chk: assert (!gt_o || (a_i > b_i));
        // R2
        top_lt_chk: assert (!lt_o || (a_i < b_i));
        // R3
        top_eq_chk: assert (!eq_o || (a_i == b_i));
        // R4
        top_onehot_chk: assert ($onehot({lt_o, gt_o, eq_o}));
    end

endmodule

// File: tb/mag_cmp4_tb.sv
module mag_cmp4_tb;

    logic       clk;
    logic       rst_n;
    logic [3:0] a;
    logic [3:0] b;
    logic       lt, gt, eq;
    int         checks;
    int         errors;
    bit         done;

    mag_cmp4 #(.WIDTH(4)) u_dut (
        .a_i  (a),
        .b_i  (b),
        .lt_o (lt),
        .gt_o (gt),
        .eq_o (eq)
    );

    initial clk = 1'b0;
    always #4 clk = ~clk;

    function automatic logic [2:0] ref_cmp(input logic [3:0] x, input logic [3:0] y);
        int ux = int'(x);
        int uy = int'(y);
        return {ux < uy, ux > uy, ux == uy};
    endfunction

    task automatic check(input string tag, input logic [2:0] act, input logic [2:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s a=%0d b=%0d actual{lt,gt,eq}=%b expected=%b", tag, a, b, act, exp);
        end
    endtask

    task automatic apply(input logic [3:0] x, input logic [3:0] y, input string tag);
        @(negedge clk);
        a = x;
        b = y;
        #2;
        check(tag, {lt, gt, eq}, ref_cmp(x, y));
        if ($countones({lt, gt, eq}) != 1) begin
            checks++;
            errors++;
            $display("FAIL R4 a=%0d b=%0d actual ones=%0d expected=1", x, y, $countones({lt, gt, eq}));
        end
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int unsigned seed;
        checks = 0;
        errors = 0;
        done   = 1'b0;
        rst_n  = 1'b0;
        a      = '0;
        b      = '0;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;

        // R3: zero operands, neutral chain start
        apply(4'd0, 4'd0, "R3 zero");
        // R8: unsigned weight of top bit
        apply(4'b1000, 4'b0111, "R8 msb weight gt");
        apply(4'b0111, 4'b1000, "R8 msb weight lt");
        // R5: higher A bit wins over lower B bits
        apply(4'b0100, 4'b0011, "R5 above override");
        apply(4'b1001, 4'b1000, "R5 lsb only");
        // R6: higher B bit wins over lower A bits
        apply(4'b0011, 4'b0100, "R6 below override");
        apply(4'b1110, 4'b1111, "R6 lsb only");
        // R7: matching upper bits forward the verdict
        apply(4'b1101, 4'b1100, "R7 forward gt");
        apply(4'b0110, 4'b0111, "R7 forward lt");
        apply(4'd15, 4'd15, "R3 all ones");

        // R1 R2 R3: every operand pair
        for (int i = 0; i < 16; i++) begin
            for (int j = 0; j < 16; j++) begin
                if (i > j)       apply(i[3:0], j[3:0], "R1 exhaustive");
                else if (i < j)  apply(i[3:0], j[3:0], "R2 exhaustive");
                else             apply(i[3:0], j[3:0], "R3 exhaustive");
            end
        end

        // R4: random pairs from a fixed seed
        seed = $urandom(32'd2024);
        for (int k = 0; k < 64; k++) begin
            logic [3:0] x;
            logic [3:0] y;
            x = 4'($urandom);
            y = 4'($urandom);
            apply(x, y, "R4 random");
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule